// File: doc/BRIEF.md
# Thirty-Two Pin GPIO Bank with Pin Interrupts

This block is one bank of general-purpose I/O pins with a small memory-mapped register port. Each pin has an output data bit, an output enable bit and an input path. The input path is synchronized, so software reads a stable value. It also feeds an interrupt detector. Every pin can be routed into the interrupt logic, enabled, and set to one of four trigger modes: falling edge, low level, rising edge or high level. A hit sets a sticky status bit, which stays set until software clears it.

Software addresses a register group with `bus_addr[6:4]` and picks an access style with `bus_addr[3:2]`. Style 0 is a plain write, style 1 is a bitwise set and style 2 is a bitwise clear. These three styles let software change single bits without a read-modify-write. All enabled status bits drive the interrupt outputs. By default the low half and the high half of the pins each drive their own line. A parameter instead folds all pins onto one line.

Top module: `gpio_bank`

## Requirements
- R1: A write with `bus_addr[3:2]=0` replaces the whole register word of the selected group. A read returns the word of the group selected by `bus_addr[6:4]`. The groups are 0 output data, 1 input data (read-only), 2 output enable, 3 routing, 4 enable, 5 level select, 6 polarity and 7 status. Addresses with `bus_addr[7]=1` or `bus_addr[1:0]!=0` read zero and write nothing.
- R2: A write with `bus_addr[3:2]=1` ORs the write data into the selected group. All other bits keep their value.
- R3: A write with `bus_addr[3:2]=2` clears the bits that are 1 in the write data. All other bits keep their value.
- R4: `pin_out` always equals the output data group, and `pin_oe` always equals the output enable group.
- R5: The input data group shows `pin_in` delayed by two clock edges through a two-flop synchronizer. Writes to this group have no effect.
- R6: A pin with level select 0 is edge-triggered. Polarity 1 sets its status bit on a rising edge of the synchronized input, and polarity 0 sets it on a falling edge. The status bit is set once per edge.
- R7: A pin with level select 1 is level-triggered. Polarity 1 means active high and polarity 0 means active low. The status bit is set again on every cycle the active level is present, so a clear has no lasting effect while that level persists.
- R8: Status bits are sticky. Only a clear-style write (group 7, `bus_addr[3:2]=2`) clears them. Plain and set-style writes to group 7 are ignored.
- R9: A pin whose routing bit is 0 never sets its status bit.
- R10: With `SPLIT_IRQ=1`, `irq_lo` is the OR of (status AND enable) over pins 0 to 15, and `irq_hi` is the same OR over pins 16 to 31. Clearing only the enable bit masks a pin while its status bit stays set.
- R11: When a status bit is set by a pin event and cleared by software in the same cycle, the bit ends up set.
- R12: After reset, output data, output enable, routing, enable, level select, polarity, status and both interrupt outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte address: group in [6:4], access style in [3:2] |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enable to the pads |
| irq_lo | output | 1 | Interrupt for pins 0 to 15 (all pins if not split) |
| irq_hi | output | 1 | Interrupt for pins 16 to 31 (zero if not split) |

## Verification
The bench drives a rising edge timed so that it lands in the same cycle as a software clear of that status bit. A design where the clear wins would drop the event and read back zero. It clears a level-triggered pin while the level is still held, which catches a design that treats levels like edges. It writes to the status group with the plain and set styles, which catches a design that lets those writes set or wipe status bits. It also checks that an event on a pin whose routing bit is 0 sets nothing. Finally, it drops only the enable bit of a high-half pin. The line must go low while the status bit stays set, and an event on a high-half pin must never reach `irq_lo`.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int GRP_DOUT  = 0;
  localparam int GRP_DIN   = 1;
  localparam int GRP_OE    = 2;
  localparam int GRP_ROUTE = 3;
  localparam int GRP_IEN   = 4;
  localparam int GRP_LVL   = 5;
  localparam int GRP_POL   = 6;
  localparam int GRP_STAT  = 7;
  localparam int NUM_GRP   = 8;

  typedef enum logic [1:0] {
    ACC_WRITE = 2'd0,
    ACC_SET   = 2'd1,
    ACC_CLR   = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic wr;
    logic set;
    logic clr;
  } wr_cmd_t;

  function automatic wr_cmd_t make_cmd(input logic hit, input acc_e acc);
    wr_cmd_t c;
    c.wr  = hit && (acc == ACC_WRITE);
    c.set = hit && (acc == ACC_SET);
    c.clr = hit && (acc == ACC_CLR);
    return c;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wr_cmd_t      cmd,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = cmd.wr | cmd.set | cmd.clr;
    q_d  = q;
    if (cmd.wr)       q_d = wdata;
    else if (cmd.set) q_d = q | wdata;
    else if (cmd.clr) q_d = q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  // R2
  set_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.set |=> (((q & $past(q)) == $past(q)) && ((q & $past(wdata)) == $past(wdata))));

  // R3
  clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clr |=> (((q & $past(wdata)) == '0) && ((q | $past(wdata)) == ($past(q) | $past(wdata)))));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] route,
  input  logic [W-1:0] lvl_sel,
  input  logic [W-1:0] pol_sel,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] trig;
  logic [W-1:0] set_mask;
  logic [W-1:0] stat_d;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, act_lvl;
    assign rise    = pin_s[i] & ~prev_q[i];
    assign fall    = ~pin_s[i] & prev_q[i];
    assign act_lvl = pol_sel[i] ? pin_s[i] : ~pin_s[i];
    assign trig[i] = lvl_sel[i] ? act_lvl : (pol_sel[i] ? rise : fall);
  end

  always_comb begin
    set_mask = trig & route;
    stat_d   = (stat_q & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= pin_s;
      stat_q <= stat_d;
    end
  end

  // R8
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R9
  route_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(route)) == '0));

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_mask & clr_mask) != '0) |=> ((stat_q & $past(set_mask)) == $past(set_mask)));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int BANK_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit SPLIT_IRQ   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BANK_W-1:0] bus_wdata,
  output logic [BANK_W-1:0] bus_rdata,
  input  logic [BANK_W-1:0] pin_in,
  output logic [BANK_W-1:0] pin_out,
  output logic [BANK_W-1:0] pin_oe,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int ACC_LSB = 2;
  localparam int GRP_LSB = 4;
  localparam int GRP_W   = $clog2(NUM_GRP);
  localparam int HALF    = BANK_W / 2;

  logic [GRP_W-1:0]  grp;
  acc_e              acc;
  logic              addr_ok;
  logic [BANK_W-1:0] grp_q [NUM_GRP];
  logic [BANK_W-1:0] pin_s;
  logic [BANK_W-1:0] stat_clr;
  logic [BANK_W-1:0] irq_act;

  always_comb begin
    grp     = bus_addr[GRP_LSB +: GRP_W];
    acc     = acc_e'(bus_addr[ACC_LSB +: 2]);
    addr_ok = (bus_addr[ADDR_W-1:GRP_LSB+GRP_W] == '0) && (bus_addr[1:0] == 2'b00);
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    if (g != GRP_DIN && g != GRP_STAT) begin : g_rw
      wr_cmd_t cmd;
      assign cmd = make_cmd(bus_we && addr_ok && (grp == GRP_W'(g)), acc);
      gpio_alias_reg #(.W(BANK_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .wdata (bus_wdata),
        .q     (grp_q[g])
      );
    end
  end

  gpio_sync #(.W(BANK_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_in),
    .sync_o  (pin_s)
  );
  assign grp_q[GRP_DIN] = pin_s;

  assign stat_clr = (bus_we && addr_ok && (grp == GRP_W'(GRP_STAT)) && (acc == ACC_CLR))
                    ? bus_wdata : '0;

  gpio_irq_detect #(.W(BANK_W)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_s    (pin_s),
    .route    (grp_q[GRP_ROUTE]),
    .lvl_sel  (grp_q[GRP_LVL]),
    .pol_sel  (grp_q[GRP_POL]),
    .clr_mask (stat_clr),
    .stat_q   (grp_q[GRP_STAT])
  );

  assign bus_rdata = addr_ok ? grp_q[grp] : '0;
  assign pin_out   = grp_q[GRP_DOUT];
  assign pin_oe    = grp_q[GRP_OE];
  assign irq_act   = grp_q[GRP_STAT] & grp_q[GRP_IEN];

  if (SPLIT_IRQ) begin : g_split
    assign irq_lo = |irq_act[HALF-1:0];
    assign irq_hi = |irq_act[BANK_W-1:HALF];
  end else begin : g_single
    assign irq_lo = |irq_act;
    assign irq_hi = 1'b0;
  end

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grp_q[GRP_STAT] & grp_q[GRP_IEN]) == '0) |-> (!irq_lo && !irq_hi));

  // R12
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (pin_out == '0 && pin_oe == '0 && !irq_lo && !irq_hi));
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_we = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe;
  logic         irq_lo, irq_hi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  function automatic logic [7:0] adr(input int grp, input int acc);
    return {1'b0, 3'(grp), 2'(acc), 2'b00};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int grp, input int acc, input logic [W-1:0] d);
    bus_we = 1'b1; bus_addr = adr(grp, acc); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int grp, output logic [W-1:0] d);
    bus_addr = adr(grp, 0);
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    for (int g = 0; g < 8; g++) begin
      rd(g, v);
      check("R12 reset group", v, '0);
    end
    check("R12 pin_out", pin_out, '0);
    check("R12 pin_oe", pin_oe, '0);
    check("R12 irq", {30'd0, irq_hi, irq_lo}, '0);
  endtask

  task automatic t_alias();
    logic [W-1:0] v;
    wr(0, 0, 32'hA5A5_0F0F);
    rd(0, v);  check("R1 plain write", v, 32'hA5A5_0F0F);
    check("R4 pin_out", pin_out, 32'hA5A5_0F0F);
    wr(0, 1, 32'h0000_F000);
    rd(0, v);  check("R2 set alias", v, 32'hA5A5_FF0F);
    wr(0, 2, 32'hA500_0001);
    rd(0, v);  check("R3 clr alias", v, 32'h00A5_FF0E);
    wr(2, 0, 32'h0F0F_1234);
    check("R4 pin_oe", pin_oe, 32'h0F0F_1234);
    bus_we = 1'b1; bus_addr = 8'h81; bus_wdata = '1;
    @(negedge clk); bus_we = 1'b0;
    rd(0, v);  check("R1 bad address ignored", v, 32'h00A5_FF0E);
  endtask

  task automatic t_din();
    logic [W-1:0] v;
    wr(1, 0, 32'hFFFF_FFFF);
    rd(1, v);  check("R5 din write ignored", v, '0);
    pin_in = 32'h0000_5678;
    tick(1);
    rd(1, v);  check("R5 din after one edge", v, '0);
    tick(1);
    rd(1, v);  check("R5 din after two edges", v, 32'h0000_5678);
    pin_in = '0;
    tick(3);
  endtask

  task automatic t_route();
    logic [W-1:0] v;
    wr(4, 0, 32'h0000_0001);
    wr(6, 0, 32'h0000_0001);
    pin_in[0] = 1'b1; tick(4);
    rd(7, v);  check("R9 unrouted pin no status", v, '0);
    check("R9 irq_lo stays low", {31'd0, irq_lo}, '0);
    pin_in[0] = 1'b0; tick(4);
  endtask

  task automatic t_edge();
    logic [W-1:0] v;
    pin_in[1] = 1'b1; tick(4);
    wr(3, 0, 32'h0000_0003);
    wr(6, 0, 32'h0000_0001);
    wr(7, 2, '1);
    pin_in[0] = 1'b1; tick(4);
    rd(7, v);  check("R6 rising edge sets", v, 32'h1);
    check("R6 irq_lo on", {31'd0, irq_lo}, 32'h1);
    wr(7, 2, 32'h1);
    rd(7, v);  check("R6 edge not held", v, '0);
    pin_in[0] = 1'b0; tick(4);
    rd(7, v);  check("R6 falling ignored on rising pin", v, '0);
    pin_in[1] = 1'b0; tick(4);
    rd(7, v);  check("R6 falling edge sets", v, 32'h2);
    wr(7, 0, 32'h0);
    wr(7, 1, 32'h8);
    rd(7, v);  check("R8 plain/set writes to status ignored", v, 32'h2);
    wr(7, 2, 32'h2);
    rd(7, v);  check("R8 clr alias empties status", v, '0);
  endtask

  task automatic t_level();
    logic [W-1:0] v;
    pin_in[3] = 1'b1; tick(4);
    wr(5, 0, 32'h0000_000C);
    wr(6, 0, 32'h0000_0004);
    wr(3, 0, 32'h0000_000C);
    wr(7, 2, '1);
    tick(1);
    rd(7, v);  check("R7 inactive levels quiet", v, '0);
    pin_in[2] = 1'b1; tick(4);
    wr(7, 2, 32'h4);
    rd(7, v);  check("R7 high level reasserts after clear", v, 32'h4);
    pin_in[2] = 1'b0; tick(4);
    wr(7, 2, 32'h4);
    rd(7, v);  check("R7 clears once level gone", v, '0);
    pin_in[3] = 1'b0; tick(4);
    wr(7, 2, 32'h8);
    rd(7, v);  check("R7 low level reasserts", v, 32'h8);
    pin_in[3] = 1'b1; tick(4);
    wr(3, 0, '0); wr(5, 0, '0); wr(6, 0, '0);
    wr(7, 2, '1);
  endtask

  task automatic t_split();
    logic [W-1:0] v;
    wr(3, 0, 32'h0010_0000);
    wr(6, 0, 32'h0010_0000);
    wr(4, 0, 32'h0010_0000);
    pin_in[20] = 1'b1; tick(4);
    check("R10 high half drives irq_hi", {30'd0, irq_hi, irq_lo}, 32'h2);
    wr(4, 2, 32'h0010_0000);
    check("R10 enable clear masks", {30'd0, irq_hi, irq_lo}, '0);
    rd(7, v);  check("R10 status kept while masked", v, 32'h0010_0000);
    pin_in[20] = 1'b0; tick(4);
    wr(7, 2, '1);
  endtask

  task automatic t_setwins();
    logic [W-1:0] v;
    wr(3, 0, 32'h0000_0010);
    wr(6, 0, 32'h0000_0010);
    pin_in[4] = 1'b1; tick(4);
    pin_in[4] = 1'b0; tick(4);
    rd(7, v);  check("R11 prior status", v, 32'h10);
    pin_in[4] = 1'b1;
    tick(2);
    wr(7, 2, 32'h10);
    rd(7, v);  check("R11 set wins over clear", v, 32'h10);
    wr(7, 2, 32'h10);
    rd(7, v);  check("R11 later clear works", v, '0);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_alias();
    t_din();
    t_route();
    t_edge();
    t_level();
    t_split();
    t_setwins();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule